// File: doc/BRIEF.md
# Three-Level Transfer Request Queue with Empty Status

This block holds pending data-movement requests in three priority queues (urgent, high and low) and hands them to a downstream transfer engine through one service port. It does not carry out the transfers. It only stores request descriptors, picks which one leaves next, and reports which levels are fully quiet.

There are two requester ports, and each is tied to a class of levels.

- **Cache-controller port.** Requests from this port always go to the urgent level.
- **Host/DMA port.** This port names its own level. Only high and low are legal for it. If it names any other level, the request is dropped and an error pulse is raised.

The service port always offers the head of the most urgent queue that may be served. Each level also tracks how many of its popped requests are still in service. A per-level completion pulse retires them one at a time.

Software reads a 32-bit status word. Bit *i* is 1 when level *i* has nothing queued and nothing in service. After reset every bit reads 1, since all levels start idle. Reading bit 0 as 1 therefore means every cache-controller request has finished.

Top module: `xfer_prio_queue_status`

## Requirements
- R1: After reset no service request is offered, both requester ports are ready, and a status read returns 0x0000_0007.
- R2: A cache-controller submission is accepted when `cc_valid` and `cc_ready` are both high. It is always queued at level 0 (urgent).
- R3: A host/DMA submission whose `hd_level` is 1 (high) or 2 (low) is queued at that level. A submission naming level 0 or 3 is handshaken (`hd_ready` high) but changes no queue. It raises `hd_err` for exactly the next cycle.
- R4: The service port offers the lowest-numbered level that has a queued entry and is below its in-service limit. `svc_level` gives that level number (0 = urgent, 1 = high, 2 = low).
- R5: Within one level, descriptors leave in the order they were accepted.
- R6: A level whose queue holds QDEPTH entries refuses new work. `cc_ready` falls when level 0 is full. `hd_ready` falls when the level named by a legal `hd_level` is full.
- R7: Status bit *i* (bit 0 = urgent, 1 = high, 2 = low) is 1 exactly when queue *i* is empty and level *i* has no request in service. A popped request stays in service until a `svc_done[i]` pulse retires it.
- R8: A `svc_done[i]` pulse is ignored when level *i* has no request in service.
- R9: A level with INFL_MAX requests in service is not offered. Lower levels may be served in its place.
- R10: A pop happens on every cycle where `svc_valid` and `svc_ready` are both high, so back-to-back cycles each retire one request.
- R11: `stat_data` is loaded on the cycle after `stat_rd`. Bits 31:3 are 0, and bits 2:0 are the status from the cycle of the read. Between reads the value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cc_valid | input | 1 | Cache-controller request present |
| cc_desc | input | DESC_W | Cache-controller request descriptor |
| cc_ready | output | 1 | Urgent queue has room |
| hd_valid | input | 1 | Host/DMA request present |
| hd_level | input | 2 | Requested level, legal values 1 and 2 |
| hd_desc | input | DESC_W | Host/DMA request descriptor |
| hd_ready | output | 1 | Named level has room (high for illegal levels) |
| hd_err | output | 1 | One-cycle pulse after an illegal-level submission |
| svc_valid | output | 1 | A request is offered to the service side |
| svc_ready | input | 1 | Service side takes the offered request |
| svc_level | output | 2 | Level of the offered request |
| svc_desc | output | DESC_W | Descriptor of the offered request |
| svc_done | input | 3 | Per-level completion pulse for a request in service |
| stat_rd | input | 1 | Status register read strobe |
| stat_data | output | STAT_W | Status word, loaded one cycle after `stat_rd` |

## Verification
Suppose a queue pointer or count goes wrong. The next offered descriptor or level then differs from the bench model at once, and the ready flags go wrong as soon as that queue nears full.

Suppose the in-service counter drifts. The fault shows first as a status bit that stays low, or returns to 1 too early, on the first read after the queue drains. It can also show as a level being skipped, or offered, when the limit should forbid it.

An error or status register that loads on the wrong cycle differs from the model at the very next sample.

// File: rtl/xpq_pkg.sv
package xpq_pkg;
   localparam int unsigned NUM_LVL = 3;
   localparam int unsigned LVL_W   = 2;

   typedef enum logic [LVL_W-1:0] {
      LVL_URGENT = 2'd0,
      LVL_HIGH   = 2'd1,
      LVL_LOW    = 2'd2,
      LVL_NONE   = 2'd3
   } lvl_e;

   function automatic logic host_level_ok(input logic [LVL_W-1:0] lvl);
      return (lvl == LVL_HIGH) || (lvl == LVL_LOW);
   endfunction
endpackage

// File: rtl/xpq_fifo.sv
module xpq_fifo #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;
   logic [CNT_W-1:0] cnt;

   initial begin
      assert (DEPTH >= 1) else $error("xpq_fifo: DEPTH must be at least 1");
      assert (WIDTH >= 1) else $error("xpq_fifo: WIDTH must be at least 1");
   end

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= ptr_inc(wr_ptr);
         if (pop)  rd_ptr <= ptr_inc(rd_ptr);
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   assign head  = mem[rd_ptr];
   assign full  = (cnt == CNT_W'(DEPTH));
   assign empty = (cnt == '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R6
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R4
   AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n) (push && !pop) |=> !empty); // R5
endmodule

// File: rtl/xpq_inflight.sv
module xpq_inflight #(
   parameter int unsigned MAX = 4,
   localparam int unsigned CW = $clog2(MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic done,
   output logic at_max,
   output logic idle
);
   logic [CW-1:0] cnt;
   logic          dec;

   initial begin
      assert (MAX >= 1) else $error("xpq_inflight: MAX must be at least 1");
   end

   assign dec = done && (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + CW'(inc) - CW'(dec);
   end

   assign at_max = (cnt == CW'(MAX));
   assign idle   = (cnt == '0);

   AST_INFL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) at_max |-> !inc); // R9
   AST_DONE_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (idle && done && !inc) |=> idle); // R8
   AST_INC_BUSY: assert property (@(posedge clk) disable iff (!rst_n) inc |=> !idle); // R7
endmodule

// File: rtl/xpq_prio_arb.sv
module xpq_prio_arb #(
   parameter int unsigned N     = 3,
   parameter int unsigned IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   initial begin
      assert (N >= 1 && (1 << IDX_W) >= N) else $error("xpq_prio_arb: IDX_W too narrow for N");
   end

   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
         end
      end
   end

   assign any = |req;
endmodule

// File: rtl/xfer_prio_queue_status.sv
module xfer_prio_queue_status
   import xpq_pkg::*;
#(
   parameter int unsigned DESC_W   = 16,
   parameter int unsigned QDEPTH   = 4,
   parameter int unsigned INFL_MAX = 4,
   parameter int unsigned STAT_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cc_valid,
   input  logic [DESC_W-1:0] cc_desc,
   output logic              cc_ready,
   input  logic              hd_valid,
   input  logic [1:0]        hd_level,
   input  logic [DESC_W-1:0] hd_desc,
   output logic              hd_ready,
   output logic              hd_err,
   output logic              svc_valid,
   input  logic              svc_ready,
   output logic [1:0]        svc_level,
   output logic [DESC_W-1:0] svc_desc,
   input  logic [2:0]        svc_done,
   input  logic              stat_rd,
   output logic [STAT_W-1:0] stat_data
);
   localparam int unsigned NL = NUM_LVL;

   logic [NL-1:0]     push, pop, full, empty, at_max, idle, elig, grant;
   logic [DESC_W-1:0] head [NL];
   logic [NL-1:0]     status_now;
   logic              hd_lvl_ok;
   logic              svc_any;
   logic [LVL_W-1:0]  svc_idx;

   initial begin
      assert (STAT_W >= NL) else $error("status word narrower than level count");
      assert (QDEPTH >= 1) else $error("QDEPTH must be at least 1");
      assert (INFL_MAX >= 1) else $error("INFL_MAX must be at least 1");
   end

   assign hd_lvl_ok = host_level_ok(hd_level);
   assign cc_ready  = !full[LVL_URGENT];

   always_comb begin
      hd_ready = 1'b1;
      for (int i = 1; i < NL; i++) begin
         if (hd_level == LVL_W'(i)) hd_ready = !full[i];
      end
   end

   for (genvar g = 0; g < NL; g++) begin : g_lvl
      logic [DESC_W-1:0] src_desc;
      if (g == 0) begin : g_cache_src
         assign push[g]  = cc_valid && !full[g];
         assign src_desc = cc_desc;
      end else begin : g_host_src
         assign push[g]  = hd_valid && (hd_level == LVL_W'(g)) && !full[g];
         assign src_desc = hd_desc;
      end

      xpq_fifo #(.WIDTH(DESC_W), .DEPTH(QDEPTH)) u_q (
         .clk(clk), .rst_n(rst_n),
         .push(push[g]), .push_data(src_desc), .pop(pop[g]),
         .head(head[g]), .full(full[g]), .empty(empty[g])
      );

      xpq_inflight #(.MAX(INFL_MAX)) u_infl (
         .clk(clk), .rst_n(rst_n),
         .inc(pop[g]), .done(svc_done[g]),
         .at_max(at_max[g]), .idle(idle[g])
      );

      assign elig[g]       = !empty[g] && !at_max[g];
      assign pop[g]        = grant[g] && svc_ready;
      assign status_now[g] = empty[g] && idle[g];
   end

   xpq_prio_arb #(.N(NL), .IDX_W(LVL_W)) u_arb (
      .req(elig), .grant(grant), .idx(svc_idx), .any(svc_any)
   );

   assign svc_valid = svc_any;
   assign svc_level = svc_idx;

   always_comb begin
      svc_desc = '0;
      for (int i = 0; i < NL; i++) begin
         if (grant[i]) svc_desc = head[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hd_err    <= 1'b0;
         stat_data <= STAT_W'({NL{1'b1}});
      end else begin
         hd_err <= hd_valid && !hd_lvl_ok;
         if (stat_rd) stat_data <= STAT_W'(status_now);
      end
   end

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) hd_err |-> $past(hd_valid && !host_level_ok(hd_level))); // R3
   AST_BAD_LVL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (hd_valid && !hd_lvl_ok) |-> (push[2:1] == 2'b00)); // R3
   AST_STRICT_PRIO: assert property (@(posedge clk) disable iff (!rst_n) (svc_valid && svc_level != 2'd0) |-> (empty[0] || at_max[0])); // R4
   AST_STATUS_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && status_now[0]) |=> (stat_data[0] && stat_data[STAT_W-1:NL] == '0)); // R11
   AST_STATUS_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) status_now[0] |-> !svc_valid || svc_level != 2'd0); // R7
endmodule

// File: tb/xfer_prio_queue_status_test.sv
`timescale 1ns/1ps
module xfer_prio_queue_status_test;
   localparam int DW = 16;
   localparam int QD = 4;
   localparam int IM = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cc_valid = 1'b0, hd_valid = 1'b0, svc_ready = 1'b0, stat_rd = 1'b0;
   logic [DW-1:0] cc_desc = '0, hd_desc = '0;
   logic [1:0]    hd_level = '0;
   logic [2:0]    svc_done = '0;
   logic          cc_ready, hd_ready, hd_err, svc_valid;
   logic [1:0]    svc_level;
   logic [DW-1:0] svc_desc;
   logic [31:0]   stat_data;

   xfer_prio_queue_status #(.DESC_W(DW), .QDEPTH(QD), .INFL_MAX(IM), .STAT_W(32)) uut (
      .clk(clk), .rst_n(rst_n),
      .cc_valid(cc_valid), .cc_desc(cc_desc), .cc_ready(cc_ready),
      .hd_valid(hd_valid), .hd_level(hd_level), .hd_desc(hd_desc),
      .hd_ready(hd_ready), .hd_err(hd_err),
      .svc_valid(svc_valid), .svc_ready(svc_ready), .svc_level(svc_level),
      .svc_desc(svc_desc), .svc_done(svc_done),
      .stat_rd(stat_rd), .stat_data(stat_data)
   );

   always #10 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;

   logic [DW-1:0] mq [3][QD];
   int            mc [3];
   int            mi [3];
   logic          pend_err = 1'b0;
   logic [31:0]   stat_hold = 32'h7;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] exp_status();
      logic [2:0] s;
      for (int i = 0; i < 3; i++) s[i] = (mc[i] == 0) && (mi[i] == 0);
      return s;
   endfunction

   function automatic int exp_pick();
      int sel = -1;
      for (int i = 0; i < 3; i++) if (sel < 0 && mc[i] > 0 && mi[i] < IM) sel = i;
      return sel;
   endfunction

   task automatic model_push(input int lvl, input logic [DW-1:0] d);
      mq[lvl][mc[lvl]] = d;
      mc[lvl]++;
   endtask

   task automatic step(input logic ccv, input logic [DW-1:0] ccd, input logic hdv,
                       input logic [1:0] hdl, input logic [DW-1:0] hdd, input logic sr,
                       input logic [2:0] dn, input logic rd);
      int  sel;
      logic hd_ok, e_ccr, e_hdr;
      logic [2:0] st;
      @(negedge clk);
      chk("R3 err pulse", 32'(hd_err), 32'(pend_err));
      chk("R11 status word", stat_data, stat_hold);
      cc_valid = ccv; cc_desc = ccd; hd_valid = hdv; hd_level = hdl; hd_desc = hdd;
      svc_ready = sr; svc_done = dn; stat_rd = rd;
      #2;
      hd_ok = (hdl == 2'd1) || (hdl == 2'd2);
      e_ccr = mc[0] < QD;
      e_hdr = hd_ok ? (mc[hdl] < QD) : 1'b1;
      sel   = exp_pick();
      st    = exp_status();
      chk("R2/R6 cc_ready", 32'(cc_ready), 32'(e_ccr));
      chk("R3/R6 hd_ready", 32'(hd_ready), 32'(e_hdr));
      chk("R4/R9/R10 svc_valid", 32'(svc_valid), 32'(sel >= 0));
      if (sel >= 0) begin
         chk("R4 svc_level", 32'(svc_level), 32'(sel));
         chk("R5 svc_desc", 32'(svc_desc), 32'(mq[sel][0]));
      end
      pend_err = hdv && !hd_ok;
      if (rd) stat_hold = {29'd0, st};
      if (sel >= 0 && sr) begin
         for (int k = 0; k < QD - 1; k++) mq[sel][k] = mq[sel][k+1];
         mc[sel]--;
      end
      if (ccv && e_ccr) model_push(0, ccd);
      if (hdv && hd_ok && e_hdr) model_push(int'(hdl), hdd);
      for (int i = 0; i < 3; i++) begin
         int inc = (sel == i && sr) ? 1 : 0;
         int dec = (dn[i] && mi[i] > 0) ? 1 : 0;
         mi[i] = mi[i] + inc - dec;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 3; i++) begin mc[i] = 0; mi[i] = 0; end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset svc_valid", 32'(svc_valid), 32'd0);
      chk("R1 reset cc_ready", 32'(cc_ready), 32'd1);
      chk("R1 reset hd_ready", 32'(hd_ready), 32'd1);
      step(0, 0, 0, 0, 0, 0, 3'b000, 1);
      step(0, 0, 0, 0, 0, 0, 3'b000, 0);
      chk("R1 reset status", stat_data, 32'h0000_0007);
      // R3: illegal levels 0 and 3, then confirm queues untouched via status read
      step(0, 0, 1, 2'd0, 16'hDEAD, 0, 3'b000, 1);
      step(0, 0, 1, 2'd3, 16'hBEEF, 0, 3'b000, 1);
      step(0, 0, 0, 0, 0, 0, 3'b000, 1);
      // R6: fill low level past depth
      for (int k = 0; k < QD + 1; k++) step(0, 0, 1, 2'd2, 16'h2000 + 16'(k), 0, 3'b000, 0);
      // R2/R4: urgent request overtakes queued low ones
      step(1, 16'h0A0A, 0, 0, 0, 0, 3'b000, 1);
      step(0, 0, 1, 2'd1, 16'h1111, 0, 3'b000, 0);
      // R10: back-to-back pops; R9: low level hits in-service limit
      for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 0, 1, 3'b000, 1);
      step(0, 0, 1, 2'd2, 16'h2F2F, 1, 3'b000, 1);
      step(0, 0, 0, 0, 0, 1, 3'b000, 1);
      // R7/R8: retire with done pulses, extra pulses ignored
      for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 1, 3'b111, 1);
      step(0, 0, 0, 0, 0, 0, 3'b111, 1);
      step(0, 0, 0, 0, 0, 0, 3'b000, 1);
      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [1:0] lv;
         logic [2:0] dn;
         lv = 2'($urandom_range(0, 3));
         for (int i = 0; i < 3; i++) dn[i] = ($urandom_range(0, 99) < 35);
         step(($urandom_range(0, 99) < 30), 16'($urandom), ($urandom_range(0, 99) < 55),
              lv, 16'($urandom), ($urandom_range(0, 99) < 45), dn, ($urandom_range(0, 1) == 1));
      end
      for (int k = 0; k < 40; k++) step(0, 0, 0, 0, 0, 1, 3'b111, 1);
      step(0, 0, 0, 0, 0, 0, 3'b000, 0);
      chk("R7 final idle status", stat_data, 32'h0000_0007);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule